// File: doc/BRIEF.md
# Segment Blink and Dual-Display Sequencer

This block sits between two segment memories and the segment driver. The memories are the main display image and a secondary image that doubles as the blink mask. The block decides, one frame at a time, which segment bits are driven. A two-bit mode picks the behaviour. The modes are: steady display with a manual memory choice, blinking only the masked segments, blinking every segment, and automatic alternation between the two images. A divider clocked by the same clock that times the LCD frames sets the blink rate. The divider is built from a prescaler and a divider field.

The host writes either memory in bytes. A clear request wipes one memory word by word. The clear flag of that memory stays high while the wipe runs and drops by itself when the wipe is done. Every visible change of phase or memory choice waits for the frame-boundary strobe, so a frame is never split between two images.

Top module: `seg_blink_seq`

## Requirements
- R1: In mode 0 (`mode` = 2'b00), `disp_sel` = 0 shows the main memory and `disp_sel` = 1 shows the secondary memory. A change of `disp_sel` only takes effect at the clock edge where `frame_strobe` is high.
- R2: In mode 0 the blink divider is held at zero and no segment is blanked. After reset both memories are zero and every output is low.
- R3: In mode 1 (2'b01), the first frame strobe after entry starts the blank phase. During the blank phase `seg_out` equals main AND NOT secondary. Before that strobe, `seg_out` equals the main memory.
- R4: In mode 2 (2'b10), `seg_out` is all zero during the blank phase. The blank phase starts at the first frame strobe after entry.
- R5: Half a blink period is (DIV+1)·2^(8+PRE) clock cycles, counted from the mode-entry edge. When that count expires, a phase toggle is recorded as pending. The pending toggle is applied at a later frame strobe, never at a strobe on the expiry edge itself, and never between strobes.
- R6: In mode 3 (2'b11), the main memory is shown first. The secondary memory is shown after the first frame strobe that follows the first half period.
- R7: `show_blink` is high exactly when the secondary memory is the displayed image. That is the latched manual choice in mode 0, the second phase in mode 3, and never in modes 1 and 2.
- R8: `com_from_blink` shows which memory supplies the common-line assignment. It equals the latched manual choice in mode 0 and is low in every other mode.
- R9: A clear pulse zeroes every word of its memory, one word per cycle. Its busy output is high for exactly NSEG/8 cycles and then falls by itself. Writes to that memory issued with the pulse or while busy are dropped.
- R10: Byte address k of either memory holds segments 8k+7 down to 8k. Bit j of the secondary memory belongs to the same segment as bit j of the main memory.
- R11: `blk_pre` and `blk_div` are only captured while `mode` is 0. Changes made in other modes are ignored until mode 0 returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LCD clock, also the blink time base |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 steady, 1 masked blink, 2 blink all, 3 alternate |
| disp_sel | input | 1 | Manual memory choice for mode 0 |
| blk_pre | input | PRE_W (3) | Blink prescaler exponent PRE |
| blk_div | input | DIV_W (3) | Blink divider DIV |
| frame_strobe | input | 1 | One-cycle frame-boundary pulse |
| wr_en | input | 1 | Byte write enable |
| wr_blink | input | 1 | Write target: 0 main, 1 secondary |
| wr_addr | input | AW (2) | Byte address |
| wr_data | input | 8 | Byte data |
| clr_main | input | 1 | Start wipe of main memory |
| clr_blink | input | 1 | Start wipe of secondary memory |
| seg_out | output | NSEG (32) | Segment on/off vector |
| show_blink | output | 1 | Secondary memory is displayed |
| com_from_blink | output | 1 | Common-line assignment taken from secondary memory |
| clr_main_busy | output | 1 | Main wipe in progress |
| clr_blink_busy | output | 1 | Secondary wipe in progress |

## Verification
The half-period expiry and a frame strobe can land on the same edge. The bench provokes this by counting edges from the mode-entry edge. It places a strobe exactly on the expiry edge and expects no change. It then places a strobe on the next edge and expects the phase to flip. Likewise, a clear pulse and a write to the same memory are issued in one cycle, and a write is also issued while the wipe runs. The wipe must win both times, which is judged by displaying the wiped memory afterwards.

// File: rtl/seg_blink_pkg.sv
// Shared types for the segment blink sequencer.
package seg_blink_pkg;
    typedef enum logic [1:0] {
        MODE_STEADY    = 2'b00,
        MODE_MASKED    = 2'b01,
        MODE_ALL       = 2'b10,
        MODE_ALTERNATE = 2'b11
    } bmode_t;
endpackage

// File: rtl/seg_mem.sv
// Byte-writable segment memory with a self-terminating word-by-word wipe.
// Assumes NSEG is a multiple of WORD_W; a wipe takes NSEG/WORD_W cycles.
module seg_mem #(
    parameter int NSEG   = 32,
    parameter int WORD_W = 8,
    localparam int NW    = NSEG / WORD_W,
    localparam int AW    = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              clr_req,
    output logic              busy,
    output logic [NSEG-1:0]   bits
);
    logic [WORD_W-1:0] words [NW];
    logic [AW-1:0]     ptr;

    // Store host bytes, or zero one word per cycle while a wipe runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ptr  <= '0;
            for (int i = 0; i < NW; i++) words[i] <= '0;
        end else if (busy) begin
            words[ptr] <= '0;
            ptr        <= ptr + 1'b1;
            if (ptr == AW'(NW - 1)) busy <= 1'b0;
        end else if (clr_req) begin
            busy <= 1'b1;
            ptr  <= '0;
        end else if (wr_en && (int'(wr_addr) < NW)) begin
            words[wr_addr] <= wr_data;
        end
    end

    // Flatten words so byte k covers segments 8k+7..8k.
    for (genvar g = 0; g < NW; g++) begin : g_flat
        assign bits[g*WORD_W +: WORD_W] = words[g];
    end

    a_r9_wipe_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> bits == '0);
    a_r9_wipe_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !busy) |=> busy);
endmodule

// File: rtl/blink_div.sv
// Blink rate divider: flags every half period of (DIV+1)*2^(8+PRE) cycles.
// Captures PRE/DIV only while hold is high; counter restarts on restart.
module blink_div #(
    parameter int PRE_W  = 3,
    parameter int DIV_W  = 3,
    localparam int CNT_W = DIV_W + 8 + (2**PRE_W - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre_in,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   half_len;

    // Half period length from the captured settings.
    always_comb begin
        half_len = ({{(CNT_W+1-DIV_W){1'b0}}, div_q} + 1'b1) << (8 + pre_q);
    end

    assign tick = !restart && (cnt == CNT_W'(half_len - 1'b1));

    // Capture rate settings while blinking is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            div_q <= '0;
        end else if (hold) begin
            pre_q <= pre_in;
            div_q <= div_in;
        end
    end

    // Count cycles within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    a_r2_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));
    a_r11_frozen_rate: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> ($stable(pre_q) && $stable(div_q)));
endmodule

// File: rtl/blink_phase.sv
// Frame-synchronous phase sequencer and display mux.
// Assumes frame_strobe is a one-cycle pulse; all image changes wait for it.
module blink_phase
    import seg_blink_pkg::*;
#(
    parameter int NSEG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic            disp_sel,
    input  logic            frame_strobe,
    input  logic            tick,
    input  logic [NSEG-1:0] main_bits,
    input  logic [NSEG-1:0] blink_bits,
    output logic            hold,
    output logic            restart,
    output logic [NSEG-1:0] seg_out,
    output logic            show_blink,
    output logic            com_from_blink
);
    bmode_t mode_in, mode_q;
    logic   ph, pend, man_q;

    assign mode_in = bmode_t'(mode);
    assign hold    = (mode_in == MODE_STEADY);
    assign restart = hold || (mode_in != mode_q);

    // Track mode, manual choice, and pending/applied phase toggles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_STEADY;
            ph     <= 1'b0;
            pend   <= 1'b0;
            man_q  <= 1'b0;
        end else begin
            mode_q <= mode_in;
            if (frame_strobe) man_q <= disp_sel;
            if (restart) begin
                ph   <= 1'b0;
                pend <= (mode_in == MODE_MASKED) || (mode_in == MODE_ALL);
            end else if (frame_strobe && pend) begin
                ph   <= ~ph;
                pend <= tick;
            end else if (tick) begin
                pend <= 1'b1;
            end
        end
    end

    // Pick the image driven to the segments this frame.
    always_comb begin
        unique case (mode_q)
            MODE_STEADY:    seg_out = man_q ? blink_bits : main_bits;
            MODE_MASKED:    seg_out = ph ? (main_bits & ~blink_bits) : main_bits;
            MODE_ALL:       seg_out = ph ? '0 : main_bits;
            MODE_ALTERNATE: seg_out = ph ? blink_bits : main_bits;
            default:        seg_out = main_bits;
        endcase
    end

    assign show_blink     = ((mode_q == MODE_STEADY) && man_q) ||
                            ((mode_q == MODE_ALTERNATE) && ph);
    assign com_from_blink = (mode_q == MODE_STEADY) && man_q;

    a_r5_phase_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_strobe && !restart) |=> $stable(ph));
    a_r1_select_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> $stable(man_q));
    a_r4_all_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ALL && ph) |-> (seg_out == '0));
    a_r2_steady_idle: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!ph && !pend));
endmodule

// File: rtl/seg_blink_seq.sv
// Top: two segment memories, blink divider and frame-synchronous sequencer.
// Assumes one clock drives both the frame timing and the blink divider.
module seg_blink_seq #(
    parameter int NSEG   = 32,
    parameter int PRE_W  = 3,
    parameter int DIV_W  = 3,
    localparam int WORD_W = 8,
    localparam int NW     = NSEG / WORD_W,
    localparam int AW     = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              disp_sel,
    input  logic [PRE_W-1:0]  blk_pre,
    input  logic [DIV_W-1:0]  blk_div,
    input  logic              frame_strobe,
    input  logic              wr_en,
    input  logic              wr_blink,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              clr_main,
    input  logic              clr_blink,
    output logic [NSEG-1:0]   seg_out,
    output logic              show_blink,
    output logic              com_from_blink,
    output logic              clr_main_busy,
    output logic              clr_blink_busy
);
    logic [NSEG-1:0] mem_bits [2];
    logic [1:0]      mem_busy;
    logic [1:0]      mem_clr;
    logic            hold, restart, tick;

    assign mem_clr = {clr_blink, clr_main};

    // Index 0 is the main memory, index 1 the secondary memory.
    for (genvar m = 0; m < 2; m++) begin : g_mem
        seg_mem #(.NSEG(NSEG), .WORD_W(WORD_W)) u_mem (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_blink == (m == 1))),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .clr_req (mem_clr[m]),
            .busy    (mem_busy[m]),
            .bits    (mem_bits[m])
        );
    end

    assign clr_main_busy  = mem_busy[0];
    assign clr_blink_busy = mem_busy[1];

    blink_div #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .restart (restart),
        .pre_in  (blk_pre),
        .div_in  (blk_div),
        .tick    (tick)
    );

    blink_phase #(.NSEG(NSEG)) u_phase (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode           (mode),
        .disp_sel       (disp_sel),
        .frame_strobe   (frame_strobe),
        .tick           (tick),
        .main_bits      (mem_bits[0]),
        .blink_bits     (mem_bits[1]),
        .hold           (hold),
        .restart        (restart),
        .seg_out        (seg_out),
        .show_blink     (show_blink),
        .com_from_blink (com_from_blink)
    );

    a_r8_com_main_when_blinking: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && $past(mode) != 2'b00) |-> !com_from_blink);
endmodule

// File: tb/seg_blink_seq_test.sv
// Scoreboard bench: driver tasks queue expected outputs, a monitor compares.
module seg_blink_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        disp_sel = 1'b0;
    logic [2:0]  blk_pre = '0;
    logic [2:0]  blk_div = '0;
    logic        frame_strobe = 1'b0;
    logic        wr_en = 1'b0, wr_blink = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        clr_main = 1'b0, clr_blink = 1'b0;
    logic [31:0] seg_out;
    logic        show_blink, com_from_blink, clr_main_busy, clr_blink_busy;

    seg_blink_seq uut (.*);

    always #5 clk = ~clk;

    typedef struct {
        logic [31:0] seg;
        logic        show, com, mbusy, bbusy;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          checks = 0, errors = 0, cyc = 0;
    bit          done = 1'b0;
    logic [31:0] e_seg = '0;
    logic        e_show = 0, e_com = 0, e_mb = 0, e_bb = 0;

    localparam logic [31:0] MAIN_IMG  = 32'h01FF3CA5;
    localparam logic [31:0] BLINK_IMG = 32'h8100F00F;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string tag);
        exp_t it;
        it.seg = e_seg; it.show = e_show; it.com = e_com;
        it.mbusy = e_mb; it.bbusy = e_bb; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(logic sel, logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_blink = sel; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic frame();
        frame_strobe = 1'b1;
        step();
        frame_strobe = 1'b0;
    endtask

    task automatic wait_to(int t);
        while (cyc < t) step();
    endtask

    // Monitor: pop queued expectations and compare away from the edge.
    always @(negedge clk) begin
        #2;
        while (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            checks++;
            if (seg_out !== it.seg || show_blink !== it.show || com_from_blink !== it.com ||
                clr_main_busy !== it.mbusy || clr_blink_busy !== it.bbusy) begin
                errors++;
                $display("FAIL %s: got seg=%h show=%b com=%b mb=%b bb=%b exp seg=%h show=%b com=%b mb=%b bb=%b",
                         it.tag, seg_out, show_blink, com_from_blink, clr_main_busy, clr_blink_busy,
                         it.seg, it.show, it.com, it.mbusy, it.bbusy);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R2 reset state");

        // R10: byte k maps to segments 8k+7..8k in both memories.
        wr(0, 0, 8'hA5); wr(0, 1, 8'h3C); wr(0, 2, 8'hFF); wr(0, 3, 8'h01);
        wr(1, 0, 8'h0F); wr(1, 1, 8'hF0); wr(1, 2, 8'h00); wr(1, 3, 8'h81);
        e_seg = MAIN_IMG;
        chk("R10 main image mapping");

        // R1: manual choice waits for a frame strobe.
        disp_sel = 1'b1;
        repeat (3) step();
        chk("R1 no change before strobe");
        frame();
        e_seg = BLINK_IMG; e_show = 1; e_com = 1;
        chk("R1 R8 secondary shown after strobe");
        disp_sel = 1'b0;
        frame();
        e_seg = MAIN_IMG; e_show = 0; e_com = 0;
        chk("R1 main shown again");

        // R3 R5 R11: masked blink, exact expiry timing, rate change ignored.
        c0 = cyc;
        mode = 2'b01;
        step();
        chk("R3 main until first strobe");
        repeat (4) step();
        blk_div = 3'd7;
        frame();
        e_seg = 32'h00FF0CA0;
        chk("R3 masked segments blank");
        wait_to(c0 + 256);
        frame();
        chk("R5 strobe on expiry edge not applied");
        frame();
        e_seg = MAIN_IMG;
        chk("R5 R11 toggle after half period");
        repeat (20) step();
        chk("R5 no mid-frame change");

        // R4: blink all.
        mode = 2'b00; blk_div = 3'd0;
        step();
        chk("R2 steady shows main");
        mode = 2'b10;
        step();
        chk("R4 main until strobe");
        frame();
        e_seg = '0;
        chk("R4 all segments dark");

        // R6: alternate with prescaler 1 (half = 512 cycles).
        mode = 2'b00; blk_pre = 3'd1;
        repeat (2) step();
        e_seg = MAIN_IMG;
        chk("R2 blanking stops in steady mode");
        c0 = cyc;
        mode = 2'b11;
        step();
        frame();
        chk("R6 main first half");
        wait_to(c0 + 512);
        frame();
        chk("R5 R6 expiry edge strobe ignored");
        frame();
        e_seg = BLINK_IMG; e_show = 1; e_com = 0;
        chk("R6 R7 R8 secondary second half");

        mode = 2'b00;
        step();
        e_seg = MAIN_IMG; e_show = 0;
        chk("R7 steady returns to main");

        // R9: wipe secondary; write with pulse and during wipe dropped.
        clr_blink = 1'b1; wr_en = 1'b1; wr_blink = 1'b1; wr_addr = 2'd0; wr_data = 8'hFF;
        step();
        clr_blink = 1'b0; wr_en = 1'b0;
        e_bb = 1;
        chk("R9 busy after clear");
        wr(1, 1, 8'h55);
        repeat (2) step();
        chk("R9 still busy");
        step();
        e_bb = 0;
        chk("R9 busy self-clears");
        disp_sel = 1'b1;
        frame();
        e_seg = '0; e_show = 1; e_com = 1;
        chk("R9 secondary wiped, writes dropped");
        wr(1, 2, 8'h3C);
        e_seg = 32'h003C0000;
        chk("R10 byte 2 maps to segments 23..16");

        // R9: wipe main.
        clr_main = 1'b1;
        step();
        clr_main = 1'b0;
        repeat (4) step();
        disp_sel = 1'b0;
        frame();
        e_seg = '0; e_show = 0; e_com = 0;
        chk("R9 main wiped");

        repeat (2) step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule